// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical frame number by walking a two-level page table held in memory. A client hands in one translation at a time. The walker splits the address into two table indices and a byte offset. It fetches a first-level entry from the root table, which is named by a root frame input. That entry gives the frame of a second-level table, and the walker fetches from it next. The second-level entry supplies the final frame. Reads go out on a word-wide request port with a valid/ready handshake, and each read's data comes back on a separate response strobe after any number of cycles.

The result is a one-cycle response pulse. It carries either the 20-bit frame together with the full physical address, or a fault flag that says which table level held an entry whose valid bit was clear. When the first-level entry is invalid, the walk stops after that single read.

Top module: `pt_walker`

## Requirements
- R1: During and straight after reset the walker is idle: `req_ready` is 1, and `mem_req_valid` and `rsp_valid` are 0.
- R2: The first read goes to byte address {root frame, vaddr[31:22], 2'b00}. The root frame is the value of `root_frame` when the request is accepted.
- R3: The second read goes to byte address {first-level entry bits 31:12, vaddr[21:12], 2'b00}.
- R4: When both entries are valid, the response has `rsp_fault`=0, `rsp_frame` equal to bits 31:12 of the second-level entry, and `rsp_paddr` = {rsp_frame, vaddr[11:0]}.
- R5: A first-level entry whose bit 0 is 0 ends the walk with `rsp_fault`=1 and `rsp_level`=0, after exactly one memory read. `rsp_frame` and `rsp_paddr` are 0.
- R6: A second-level entry whose bit 0 is 0 ends the walk with `rsp_fault`=1 and `rsp_level`=1, after two reads. `rsp_frame` and `rsp_paddr` are 0.
- R7: Once `mem_req_valid` is raised, it and `mem_req_addr` hold steady until `mem_req_ready` is seen.
- R8: Only one walk runs at a time. `req_ready` stays 0 from acceptance until the response. `rsp_valid` lasts one cycle, and the walker is idle again in the next cycle.
- R9: A `mem_rsp_valid` pulse that arrives while no read is outstanding has no effect on the walk or its result.
- R10: A change on `root_frame` after a request is accepted does not affect that walk.
- R11: Entry bits 11:1 are ignored. Only bit 0 (valid) and bits 31:12 (frame) are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| root_frame | input | 20 | Frame holding the first-level table |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry word |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Walk ended on an invalid entry |
| rsp_level | output | 1 | Faulting level: 0 first, 1 second |
| rsp_frame | output | 20 | Translated frame number |
| rsp_paddr | output | 32 | Translated physical address |

## Verification
The bench models memory as a hashed word function. This gives random table contents, with about one entry in eight invalid and random filler in bits 11:1. Walks are driven with random addresses and root frames, so both fault levels and clean translations turn up naturally. Random request stalls and response latencies separate correct holding of the request from correct waiting for data. Stray response strobes between reads show whether the walker only listens while a read is outstanding. Directed cases use the all-zero and all-one addresses and roots, which would expose index or offset bits landing in the wrong field. A forced invalid entry at a chosen level pins each fault path, including the single-read early stop.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_RD1,
    WS_WT1,
    WS_RD2,
    WS_WT2,
    WS_DONE,
    WS_FLT
  } walk_state_e;

endpackage

// File: rtl/pt_pte_dec.sv
module pt_pte_dec #(
  parameter int PTE_W = 32,
  parameter int FRM_W = 20
) (
  input  logic [PTE_W-1:0] pte,
  output logic             pte_ok,
  output logic [FRM_W-1:0] pte_frame
);
  localparam int FLAG_W = PTE_W - FRM_W;

  function automatic logic entry_valid(input logic [PTE_W-1:0] e);
    return e[0];
  endfunction

  function automatic logic [FRM_W-1:0] entry_frame(input logic [PTE_W-1:0] e);
    return e[PTE_W-1 -: FRM_W];
  endfunction

  logic pte_unused_bits;

  assign pte_ok          = entry_valid(pte);
  assign pte_frame       = entry_frame(pte);
  assign pte_unused_bits = ^pte[FLAG_W-1:1];

endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int FRM_W  = 20,
  parameter int IDX_W  = 10,
  parameter int ENT_LG = 2
) (
  input  logic                      sel_l2,
  input  logic [FRM_W-1:0]          root_frm,
  input  logic [FRM_W-1:0]          tbl_frm,
  input  logic [IDX_W-1:0]          idx_l1,
  input  logic [IDX_W-1:0]          idx_l2,
  output logic [FRM_W+IDX_W+ENT_LG-1:0] addr
);
  localparam int ADDR_W = FRM_W + IDX_W + ENT_LG;

  function automatic logic [ADDR_W-1:0] entry_addr(input logic [FRM_W-1:0] frm,
                                                   input logic [IDX_W-1:0] idx);
    return {frm, idx, {ENT_LG{1'b0}}};
  endfunction

  assign addr = sel_l2 ? entry_addr(tbl_frm, idx_l2) : entry_addr(root_frm, idx_l1);

endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        mem_req_ready,
  input  logic        mem_rsp_valid,
  input  logic        pte_ok,
  output walk_state_e state_o,
  output logic        req_ready,
  output logic        mem_req_valid,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic        evt_accept,
  output logic        evt_l1_ok,
  output logic        evt_l2_ok,
  output logic        evt_flt_l1,
  output logic        evt_flt_l2
);
  walk_state_e st_q, st_d;

  assign req_ready     = (st_q == WS_IDLE);
  assign mem_req_valid = (st_q == WS_RD1) || (st_q == WS_RD2);
  assign rsp_valid     = (st_q == WS_DONE) || (st_q == WS_FLT);
  assign rsp_fault     = (st_q == WS_FLT);
  assign evt_accept    = req_ready && req_valid;
  assign evt_l1_ok     = (st_q == WS_WT1) && mem_rsp_valid && pte_ok;
  assign evt_flt_l1    = (st_q == WS_WT1) && mem_rsp_valid && !pte_ok;
  assign evt_l2_ok     = (st_q == WS_WT2) && mem_rsp_valid && pte_ok;
  assign evt_flt_l2    = (st_q == WS_WT2) && mem_rsp_valid && !pte_ok;
  assign state_o       = st_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      WS_IDLE: if (req_valid)     st_d = WS_RD1;
      WS_RD1:  if (mem_req_ready) st_d = WS_WT1;
      WS_WT1:  if (mem_rsp_valid) st_d = pte_ok ? WS_RD2 : WS_FLT;
      WS_RD2:  if (mem_req_ready) st_d = WS_WT2;
      WS_WT2:  if (mem_rsp_valid) st_d = pte_ok ? WS_DONE : WS_FLT;
      WS_DONE: st_d = WS_IDLE;
      WS_FLT:  st_d = WS_IDLE;
      default: st_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= WS_IDLE;
    else        st_q <= st_d;
  end

  AST_L1_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_flt_l1 |=> (rsp_fault && !mem_req_valid)); // R5

  AST_L2_FAULT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_flt_l2 |=> (rsp_valid && rsp_fault)); // R6

  AST_RD_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid); // R7

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  parameter int PTE_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic [VA_W-OFF_W-1:0] root_frame,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [VA_W-1:0]       mem_req_addr,
  input  logic                  mem_rsp_valid,
  input  logic [PTE_W-1:0]      mem_rsp_data,
  output logic                  rsp_valid,
  output logic                  rsp_fault,
  output logic                  rsp_level,
  output logic [VA_W-OFF_W-1:0] rsp_frame,
  output logic [VA_W-1:0]       rsp_paddr
);
  localparam int FRM_W  = VA_W - OFF_W;
  localparam int ENT_LG = OFF_W - IDX_W;

  walk_state_e      st;
  logic             evt_accept, evt_l1_ok, evt_l2_ok, evt_flt_l1, evt_flt_l2;
  logic             pte_ok;
  logic [FRM_W-1:0] pte_frame;
  logic [VA_W-1:0]  va_q;
  logic [FRM_W-1:0] root_q, tbl_q, frm_q;
  logic             lvl_q;

  pt_walk_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .pte_ok        (pte_ok),
    .state_o       (st),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .evt_accept    (evt_accept),
    .evt_l1_ok     (evt_l1_ok),
    .evt_l2_ok     (evt_l2_ok),
    .evt_flt_l1    (evt_flt_l1),
    .evt_flt_l2    (evt_flt_l2)
  );

  pt_pte_dec #(.PTE_W(PTE_W), .FRM_W(FRM_W)) u_dec (
    .pte       (mem_rsp_data),
    .pte_ok    (pte_ok),
    .pte_frame (pte_frame)
  );

  pt_addr_gen #(.FRM_W(FRM_W), .IDX_W(IDX_W), .ENT_LG(ENT_LG)) u_agen (
    .sel_l2   (st == WS_RD2),
    .root_frm (root_q),
    .tbl_frm  (tbl_q),
    .idx_l1   (va_q[VA_W-1 -: IDX_W]),
    .idx_l2   (va_q[OFF_W +: IDX_W]),
    .addr     (mem_req_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      root_q <= '0;
      tbl_q  <= '0;
      frm_q  <= '0;
      lvl_q  <= 1'b0;
    end else begin
      if (evt_accept) begin
        va_q   <= req_vaddr;
        root_q <= root_frame;
      end
      if (evt_l1_ok)  tbl_q <= pte_frame;
      if (evt_l2_ok)  frm_q <= pte_frame;
      if (evt_flt_l1) lvl_q <= 1'b0;
      if (evt_flt_l2) lvl_q <= 1'b1;
    end
  end

  assign rsp_level = rsp_fault & lvl_q;
  assign rsp_frame = rsp_fault ? '0 : frm_q;
  assign rsp_paddr = rsp_fault ? '0 : {frm_q, va_q[OFF_W-1:0]};

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready)); // R8

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R8

  AST_REQ_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr)); // R7

  AST_OK_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && !rsp_fault) |-> $past(mem_rsp_valid)); // R4

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid); // R1

endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [19:0] root_frame = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        rsp_valid, rsp_fault, rsp_level;
  logic [19:0] rsp_frame;
  logic [31:0] rsp_paddr;

  int          total = 0;
  int          bad = 0;
  logic [31:0] bad_addr = 32'h1;
  int          rd_cnt = 0;
  logic [31:0] rd_addr [2];
  logic [31:0] held_addr = '0;
  bit          held = 1'b0;

  always #5 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .root_frame(root_frame),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_level(rsp_level), .rsp_frame(rsp_frame), .rsp_paddr(rsp_paddr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] x;
    x = a * 32'h9E3779B1;
    x = x ^ (x >> 15);
    x = x * 32'h85EBCA6B;
    x = x ^ (x >> 13);
    x[0] = (x[6:4] != 3'b000);
    if (a == bad_addr) x[0] = 1'b0;
    return x;
  endfunction

  function automatic logic [31:0] slot(input logic [19:0] frm, input logic [9:0] idx);
    return (32'(frm) << 12) + (32'(idx) * 32'd4);
  endfunction

  // memory model: random grant stalls, latency 1..4, stray strobes when nothing is outstanding
  initial begin
    int pend;
    logic [31:0] pend_addr;
    pend = 0;
    pend_addr = '0;
    forever begin
      @(negedge clk);
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = $urandom;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_word(pend_addr);
        end
      end else if (mem_req_valid === 1'b1) begin
        if (!held) begin
          held = 1'b1;
          held_addr = mem_req_addr;
        end else begin
          chk(mem_req_addr == held_addr, "R7 address held while stalled", mem_req_addr, held_addr);
        end
        if ($urandom % 3 != 0) begin
          mem_req_ready = 1'b1;
          held = 1'b0;
          if (rd_cnt < 2) rd_addr[rd_cnt] = mem_req_addr;
          rd_cnt++;
          pend_addr = mem_req_addr;
          pend = 1 + int'($urandom % 4);
        end
      end else if ($urandom % 5 == 0) begin
        mem_rsp_valid = 1'b1; // R9 stray strobe
      end
    end
  end

  task automatic run_walk(input logic [31:0] va, input logic [19:0] root);
    logic [31:0] a1, a2, e1, e2;
    bit exp_flt, exp_lvl;
    int exp_rd, waited;
    logic [19:0] exp_frm;
    logic [31:0] exp_pa;
    a1 = slot(root, va[31:22]);
    e1 = mem_word(a1);
    a2 = slot(e1[31:12], va[21:12]);
    e2 = mem_word(a2);
    if (!e1[0]) begin
      exp_flt = 1; exp_lvl = 0; exp_rd = 1; exp_frm = '0; exp_pa = '0;
    end else if (!e2[0]) begin
      exp_flt = 1; exp_lvl = 1; exp_rd = 2; exp_frm = '0; exp_pa = '0;
    end else begin
      exp_flt = 0; exp_lvl = 0; exp_rd = 2;
      exp_frm = e2[31:12];                 // R11: bits 11:1 play no part
      exp_pa  = {e2[31:12], va[11:0]};
    end
    @(negedge clk);
    rd_cnt = 0;
    req_valid = 1'b1;
    req_vaddr = va;
    root_frame = root;
    @(negedge clk);
    req_valid = 1'b0;
    req_vaddr = $urandom;
    root_frame = 20'($urandom);            // R10 root changes mid-walk
    waited = 0;
    while (rsp_valid !== 1'b1 && waited < 200) begin
      chk(req_ready == 1'b0, "R8 busy while walking", 32'(req_ready), 32'd0);
      @(negedge clk);
      waited++;
    end
    if (waited >= 200) begin
      chk(1'b0, "R8 walk response", 32'(rsp_valid), 32'd1);
    end else begin
      chk(rsp_fault == exp_flt, exp_lvl ? "R6 fault flag" : "R4/R5 fault flag", 32'(rsp_fault), 32'(exp_flt));
      chk(rsp_level == exp_lvl, exp_lvl ? "R6 fault level" : "R5 fault level", 32'(rsp_level), 32'(exp_lvl));
      chk(rsp_frame == exp_frm, "R4 frame", 32'(rsp_frame), 32'(exp_frm));
      chk(rsp_paddr == exp_pa, "R4 physical address", rsp_paddr, exp_pa);
      chk(rd_cnt == exp_rd, "R5 read count", 32'(rd_cnt), 32'(exp_rd));
      chk(rd_addr[0] == a1, "R2 R10 first read address", rd_addr[0], a1);
      if (exp_rd == 2) chk(rd_addr[1] == a2, "R3 second read address", rd_addr[1], a2);
      @(negedge clk);
      chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R8 single pulse then idle",
          {30'd0, rsp_valid, req_ready}, 32'd1);
    end
  endtask

  initial begin
    #(200000 * 10);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] va;
    logic [19:0] rt;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 32'd1);
    chk(mem_req_valid == 1'b0 && rsp_valid == 1'b0, "R1 quiet in reset",
        {30'd0, mem_req_valid, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && mem_req_valid == 1'b0, "R1 idle after reset",
        {30'd0, req_ready, mem_req_valid}, 32'd2);

    run_walk(32'h0000_0000, 20'h00000);
    run_walk(32'hFFFF_FFFF, 20'hFFFFF);
    run_walk(32'h0040_1ABC, 20'h12345);

    // forced first-level fault (R5)
    va = 32'h1234_5678; rt = 20'h0ABCD;
    bad_addr = slot(rt, va[31:22]);
    run_walk(va, rt);

    // forced second-level fault (R6): pick a walk whose first entry is valid
    va = 32'h8765_4321; rt = 20'h00100;
    while (!mem_word(slot(rt, va[31:22]))[0]) rt = rt + 20'd1;
    bad_addr = slot(mem_word(slot(rt, va[31:22]))[31:12], va[21:12]);
    run_walk(va, rt);
    bad_addr = 32'h1;

    for (int i = 0; i < 400; i++) begin
      run_walk($urandom, 20'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule